// File: doc/BRIEF.md
# Lane-Masked Vector Result Writeback

This block takes a finished 64-lane vector result and turns it into write beats for a vector register file that has a write enable for each lane. It picks the lane mask for the write from one of three sources. A load instruction uses the mask that was captured along with it. Every other instruction uses the wavefront's live execution mask. A force-all override enables all 64 lanes. Lanes whose enable is clear are left untouched by the register file, so they keep their old contents.

The result is either 32 bits wide (one register) or 64 bits wide. A 64-bit result writes its low words into register N and its high words into register N+1, and both registers use the mask chosen when the request was accepted. The variant with one write port spends two cycles on a 64-bit result and raises `busy` between the beats. The variant with two write ports issues both halves in the same cycle. A `done` strobe marks the final beat of each request.

Top module: `vreg_masked_wb`

## Requirements
- R1: While `rst` is high, and in the first cycle after a reset edge, both write ports are inactive with zero enables and zero data, and `busy` and `done` are low.
- R2: A 32-bit request accepted at a clock edge appears on port 0 in the following cycle. That beat has `wp0_en`=1, `wp0_idx` equal to the destination, `wp0_data` equal to `res_lo`, and `done`=1. Lane k uses bit k of the enable and bits [32k+31:32k] of the data.
- R3: When the override is low, a load request (`req_is_load`=1) uses `load_mask` as its lane enables and any other request uses `wave_exec`. The mask is the value present at the accepting edge.
- R4: When `req_ignore_mask`=1, all 64 lane enables are set, whatever the values of both masks and the load flag.
- R5: With one write port, a 64-bit request first writes `res_lo` to register N. In the next cycle it writes `res_hi` to register N+1, modulo 2^REG_IDX_W. Both beats use the mask captured at acceptance, even if the mask inputs change in between. `done` is high only on the second beat.
- R6: With one write port, `busy` is high only in the cycle between the two beats of a 64-bit request. A `req_valid` presented at the edge that ends that cycle is not accepted and produces no write.
- R7: With two write ports, a 64-bit request issues both beats in the same cycle: port 0 carries the low half to register N, and port 1 carries the high half to register N+1 with the same mask. `done` is high in that cycle and `busy` never rises.
- R8: A port that is not writing drives its lane enables, index and data as zero. `done` is high only in a cycle where port 0 is writing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present; accepted when `busy` is low |
| req_dst | input | REG_IDX_W | Destination register N |
| req_wide | input | 1 | 1 = 64-bit result, 0 = 32-bit result |
| req_is_load | input | 1 | Request comes from a memory load |
| req_ignore_mask | input | 1 | Force all lanes enabled |
| wave_exec | input | LANES | Live wavefront execution mask |
| load_mask | input | LANES | Mask captured with the load instruction |
| res_lo | input | LANES*ELEM_W | Low word of each lane |
| res_hi | input | LANES*ELEM_W | High word of each lane (64-bit results) |
| busy | output | 1 | Second beat pending; requests refused |
| done | output | 1 | Final beat of a request is on the ports |
| wp0_en | output | 1 | Port 0 write strobe |
| wp0_idx | output | REG_IDX_W | Port 0 register index |
| wp0_lane_we | output | LANES | Port 0 per-lane write enables |
| wp0_data | output | LANES*ELEM_W | Port 0 lane data |
| wp1_en | output | 1 | Port 1 write strobe (two-port variant) |
| wp1_idx | output | REG_IDX_W | Port 1 register index |
| wp1_lane_we | output | LANES | Port 1 per-lane write enables |
| wp1_data | output | LANES*ELEM_W | Port 1 lane data |

## Verification
The live mask can change in the same cycle that the second half of a 64-bit write is issued. A new request can also arrive in that same cycle. The bench provokes both at once: during the `busy` cycle it changes `wave_exec` and `load_mask` and presents another valid request. It then judges that the high beat still carries the first mask and that the refused request leaves no trace on the single-port instance, while the two-port instance accepts the same request and applies the new mask.

// File: rtl/vwb_pkg.sv
package vwb_pkg;

    // Which mask governs the lane enables of a write
    typedef enum logic [1:0] {
        MSK_WAVE = 2'd0,
        MSK_LOAD = 2'd1,
        MSK_ALL  = 2'd2
    } msk_src_e;

    // What port 0 carries in the next cycle
    typedef enum logic [1:0] {
        BT_IDLE = 2'd0,
        BT_SOLE = 2'd1,
        BT_LOW  = 2'd2,
        BT_HIGH = 2'd3
    } beat_e;

    function automatic msk_src_e pick_src(input logic is_load, input logic ignore);
        if (ignore)
            return MSK_ALL;
        if (is_load)
            return MSK_LOAD;
        return MSK_WAVE;
    endfunction

endpackage

// File: rtl/vwb_mask_sel.sv
module vwb_mask_sel
    import vwb_pkg::*;
#(
    parameter int LANES = 64
) (
    input  logic             is_load,
    input  logic             ignore,
    input  logic [LANES-1:0] wave_exec,
    input  logic [LANES-1:0] load_mask,
    output logic [LANES-1:0] lane_mask
);
    msk_src_e src;

    always_comb begin
        src = pick_src(is_load, ignore);
        case (src)
            MSK_ALL:  lane_mask = '1;
            MSK_LOAD: lane_mask = load_mask;
            default:  lane_mask = wave_exec;
        endcase
    end

endmodule

// File: rtl/vwb_port_reg.sv
module vwb_port_reg #(
    parameter int LANES  = 64,
    parameter int ELEM_W = 32,
    parameter int IDX_W  = 5,
    localparam int DW    = LANES * ELEM_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             n_en,
    input  logic [IDX_W-1:0] n_idx,
    input  logic [LANES-1:0] n_we,
    input  logic [DW-1:0]    n_data,
    output logic             q_en,
    output logic [IDX_W-1:0] q_idx,
    output logic [LANES-1:0] q_we,
    output logic [DW-1:0]    q_data
);
    always_ff @(posedge clk) begin
        if (rst) begin
            q_en   <= 1'b0;
            q_idx  <= '0;
            q_we   <= '0;
            q_data <= '0;
        end else begin
            q_en   <= n_en;
            q_idx  <= n_en ? n_idx  : '0;
            q_we   <= n_en ? n_we   : '0;
            q_data <= n_en ? n_data : '0;
        end
    end

    // R8: a silent port never presents lane enables or data
    p_quiet_port_r8: assert property (@(posedge clk) disable iff (rst)
        !q_en |-> (q_we == '0 && q_data == '0 && q_idx == '0));

endmodule

// File: rtl/vwb_seq.sv
module vwb_seq
    import vwb_pkg::*;
#(
    parameter int LANES     = 64,
    parameter int ELEM_W    = 32,
    parameter int IDX_W     = 5,
    parameter bit DUAL_PORT = 1'b0,
    localparam int DW       = LANES * ELEM_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             acc,
    input  logic [IDX_W-1:0] dst,
    input  logic             wide,
    input  logic [LANES-1:0] mask,
    input  logic [DW-1:0]    data_lo,
    input  logic [DW-1:0]    data_hi,
    output logic             busy,
    output logic             done,
    output logic             n0_en,
    output logic [IDX_W-1:0] n0_idx,
    output logic [LANES-1:0] n0_we,
    output logic [DW-1:0]    n0_data,
    output logic             n1_en,
    output logic [IDX_W-1:0] n1_idx,
    output logic [LANES-1:0] n1_we,
    output logic [DW-1:0]    n1_data
);
    beat_e            cur;
    logic             load_pend;
    logic             done_d;
    logic             done_q;
    logic             pend_q;
    logic [IDX_W-1:0] pidx_q;
    logic [LANES-1:0] pwe_q;
    logic [DW-1:0]    pdat_q;
    logic [IDX_W-1:0] dst_up;

    assign dst_up = dst + IDX_W'(1);

    always_comb begin
        if (pend_q)
            cur = BT_HIGH;
        else if (acc)
            cur = wide ? BT_LOW : BT_SOLE;
        else
            cur = BT_IDLE;
    end

    always_comb begin
        n0_en     = 1'b0;
        n0_idx    = '0;
        n0_we     = '0;
        n0_data   = '0;
        n1_en     = 1'b0;
        n1_idx    = '0;
        n1_we     = '0;
        n1_data   = '0;
        done_d    = 1'b0;
        load_pend = 1'b0;
        case (cur)
            BT_SOLE: begin
                n0_en   = 1'b1;
                n0_idx  = dst;
                n0_we   = mask;
                n0_data = data_lo;
                done_d  = 1'b1;
            end
            BT_LOW: begin
                n0_en   = 1'b1;
                n0_idx  = dst;
                n0_we   = mask;
                n0_data = data_lo;
                if (DUAL_PORT) begin
                    n1_en   = 1'b1;
                    n1_idx  = dst_up;
                    n1_we   = mask;
                    n1_data = data_hi;
                    done_d  = 1'b1;
                end else begin
                    load_pend = 1'b1;
                end
            end
            BT_HIGH: begin
                n0_en   = 1'b1;
                n0_idx  = pidx_q;
                n0_we   = pwe_q;
                n0_data = pdat_q;
                done_d  = 1'b1;
            end
            default: ;
        endcase
    end

    generate
        if (DUAL_PORT) begin : g_dual
            assign pend_q = 1'b0;
            assign pidx_q = '0;
            assign pwe_q  = '0;
            assign pdat_q = '0;
        end else begin : g_single
            always_ff @(posedge clk) begin
                if (rst) begin
                    pend_q <= 1'b0;
                    pidx_q <= '0;
                    pwe_q  <= '0;
                    pdat_q <= '0;
                end else if (load_pend) begin
                    pend_q <= 1'b1;
                    pidx_q <= dst_up;
                    pwe_q  <= mask;
                    pdat_q <= data_hi;
                end else begin
                    pend_q <= 1'b0;
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst)
            done_q <= 1'b0;
        else
            done_q <= done_d;
    end

    assign busy = pend_q;
    assign done = done_q;

    // R6: a pending high half never survives more than one cycle
    p_pend_once_r6: assert property (@(posedge clk) disable iff (rst)
        pend_q |=> !pend_q);

    // R5: the high half only follows an accepted low half
    p_pend_source_r5: assert property (@(posedge clk) disable iff (rst)
        (acc && wide && !DUAL_PORT) |=> pend_q);

endmodule

// File: rtl/vreg_masked_wb.sv
module vreg_masked_wb
    import vwb_pkg::*;
#(
    parameter int LANES     = 64,
    parameter int ELEM_W    = 32,
    parameter int REG_IDX_W = 5,
    parameter bit DUAL_PORT = 1'b0,
    localparam int DW       = LANES * ELEM_W
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 req_valid,
    input  logic [REG_IDX_W-1:0] req_dst,
    input  logic                 req_wide,
    input  logic                 req_is_load,
    input  logic                 req_ignore_mask,
    input  logic [LANES-1:0]     wave_exec,
    input  logic [LANES-1:0]     load_mask,
    input  logic [DW-1:0]        res_lo,
    input  logic [DW-1:0]        res_hi,
    output logic                 busy,
    output logic                 done,
    output logic                 wp0_en,
    output logic [REG_IDX_W-1:0] wp0_idx,
    output logic [LANES-1:0]     wp0_lane_we,
    output logic [DW-1:0]        wp0_data,
    output logic                 wp1_en,
    output logic [REG_IDX_W-1:0] wp1_idx,
    output logic [LANES-1:0]     wp1_lane_we,
    output logic [DW-1:0]        wp1_data
);
    logic                 accept;
    logic [LANES-1:0]     sel_mask;
    logic                 n0_en, n1_en;
    logic [REG_IDX_W-1:0] n0_idx, n1_idx;
    logic [LANES-1:0]     n0_we, n1_we;
    logic [DW-1:0]        n0_data, n1_data;

    assign accept = req_valid && !busy;

    vwb_mask_sel #(.LANES(LANES)) u_msel (
        .is_load   (req_is_load),
        .ignore    (req_ignore_mask),
        .wave_exec (wave_exec),
        .load_mask (load_mask),
        .lane_mask (sel_mask)
    );

    vwb_seq #(
        .LANES(LANES), .ELEM_W(ELEM_W), .IDX_W(REG_IDX_W), .DUAL_PORT(DUAL_PORT)
    ) u_seq (
        .clk     (clk),
        .rst     (rst),
        .acc     (accept),
        .dst     (req_dst),
        .wide    (req_wide),
        .mask    (sel_mask),
        .data_lo (res_lo),
        .data_hi (res_hi),
        .busy    (busy),
        .done    (done),
        .n0_en   (n0_en),
        .n0_idx  (n0_idx),
        .n0_we   (n0_we),
        .n0_data (n0_data),
        .n1_en   (n1_en),
        .n1_idx  (n1_idx),
        .n1_we   (n1_we),
        .n1_data (n1_data)
    );

    vwb_port_reg #(.LANES(LANES), .ELEM_W(ELEM_W), .IDX_W(REG_IDX_W)) u_p0 (
        .clk(clk), .rst(rst),
        .n_en(n0_en), .n_idx(n0_idx), .n_we(n0_we), .n_data(n0_data),
        .q_en(wp0_en), .q_idx(wp0_idx), .q_we(wp0_lane_we), .q_data(wp0_data)
    );

    vwb_port_reg #(.LANES(LANES), .ELEM_W(ELEM_W), .IDX_W(REG_IDX_W)) u_p1 (
        .clk(clk), .rst(rst),
        .n_en(n1_en), .n_idx(n1_idx), .n_we(n1_we), .n_data(n1_data),
        .q_en(wp1_en), .q_idx(wp1_idx), .q_we(wp1_lane_we), .q_data(wp1_data)
    );

    // R8: completion is only flagged alongside a port 0 write
    p_done_has_write_r8: assert property (@(posedge clk) disable iff (rst)
        done |-> wp0_en);

    // R4: the override enables every lane on the beat it produces
    p_force_all_r4: assert property (@(posedge clk) disable iff (rst)
        (accept && req_ignore_mask) |=> (&wp0_lane_we));

    // R3: a load without override writes under its captured mask
    p_load_mask_r3: assert property (@(posedge clk) disable iff (rst)
        (accept && req_is_load && !req_ignore_mask) |=> (wp0_lane_we == $past(load_mask)));

    // R5: the second beat reuses the mask and targets the next register
    p_high_beat_r5: assert property (@(posedge clk) disable iff (rst)
        busy |=> (wp0_en && done && wp0_lane_we == $past(wp0_lane_we)
                  && wp0_idx == $past(wp0_idx) + REG_IDX_W'(1)));

    // R7: port 1 only ever pairs with port 0 on the neighbouring register
    p_pair_ports_r7: assert property (@(posedge clk) disable iff (rst)
        wp1_en |-> (wp0_en && wp1_idx == wp0_idx + REG_IDX_W'(1)
                    && wp1_lane_we == wp0_lane_we));

endmodule

// File: tb/sim_vreg_masked_wb.sv
module sim_vreg_masked_wb;
    localparam int L  = 64;
    localparam int EW = 32;
    localparam int IW = 5;
    localparam int DW = L * EW;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req_valid = 1'b0;
    logic [IW-1:0] req_dst = '0;
    logic          req_wide = 1'b0;
    logic          req_is_load = 1'b0;
    logic          req_ignore_mask = 1'b0;
    logic [L-1:0]  wave_exec = '0;
    logic [L-1:0]  load_mask = '0;
    logic [DW-1:0] res_lo = '0;
    logic [DW-1:0] res_hi = '0;

    logic          a_busy, a_done, a_e0, a_e1;
    logic [IW-1:0] a_i0, a_i1;
    logic [L-1:0]  a_w0, a_w1;
    logic [DW-1:0] a_d0, a_d1;
    logic          b_busy, b_done, b_e0, b_e1;
    logic [IW-1:0] b_i0, b_i1;
    logic [L-1:0]  b_w0, b_w1;
    logic [DW-1:0] b_d0, b_d1;

    int checks = 0;
    int bad = 0;
    bit started = 1'b0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    vreg_masked_wb #(.LANES(L), .ELEM_W(EW), .REG_IDX_W(IW), .DUAL_PORT(1'b0)) u0 (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_dst(req_dst),
        .req_wide(req_wide), .req_is_load(req_is_load), .req_ignore_mask(req_ignore_mask),
        .wave_exec(wave_exec), .load_mask(load_mask), .res_lo(res_lo), .res_hi(res_hi),
        .busy(a_busy), .done(a_done),
        .wp0_en(a_e0), .wp0_idx(a_i0), .wp0_lane_we(a_w0), .wp0_data(a_d0),
        .wp1_en(a_e1), .wp1_idx(a_i1), .wp1_lane_we(a_w1), .wp1_data(a_d1));

    vreg_masked_wb #(.LANES(L), .ELEM_W(EW), .REG_IDX_W(IW), .DUAL_PORT(1'b1)) u1 (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_dst(req_dst),
        .req_wide(req_wide), .req_is_load(req_is_load), .req_ignore_mask(req_ignore_mask),
        .wave_exec(wave_exec), .load_mask(load_mask), .res_lo(res_lo), .res_hi(res_hi),
        .busy(b_busy), .done(b_done),
        .wp0_en(b_e0), .wp0_idx(b_i0), .wp0_lane_we(b_w0), .wp0_data(b_d0),
        .wp1_en(b_e1), .wp1_idx(b_i1), .wp1_lane_we(b_w1), .wp1_data(b_d1));

    // ---------------- behavioural reference ----------------
    typedef struct {
        logic [IW-1:0] idx;
        logic [L-1:0]  we;
        logic [DW-1:0] dat;
    } beat_t;

    beat_t hq[$];

    logic          ma_busy, ma_done, ma_e0;
    logic [IW-1:0] ma_i0;
    logic [L-1:0]  ma_w0;
    logic [DW-1:0] ma_d0;
    string         ma_tag;
    logic          mb_done, mb_e0, mb_e1;
    logic [IW-1:0] mb_i0, mb_i1;
    logic [L-1:0]  mb_w0, mb_w1;
    logic [DW-1:0] mb_d0, mb_d1;
    string         mb_tag;

    function automatic logic [L-1:0] want_mask();
        if (req_ignore_mask) return '1;
        if (req_is_load) return load_mask;
        return wave_exec;
    endfunction

    function automatic string mask_tag();
        if (req_ignore_mask) return "R4";
        if (req_is_load) return "R3";
        return "R2";
    endfunction

    always @(posedge clk) begin
        beat_t b;
        logic [L-1:0] m;
        started = 1'b1;
        m = want_mask();
        // single-port reference
        ma_busy = 1'b0; ma_done = 1'b0; ma_e0 = 1'b0;
        ma_i0 = '0; ma_w0 = '0; ma_d0 = '0;
        if (rst) begin
            hq.delete();
            ma_tag = "R1";
        end else if (hq.size() > 0) begin
            b = hq.pop_front();
            ma_e0 = 1'b1; ma_i0 = b.idx; ma_w0 = b.we; ma_d0 = b.dat;
            ma_done = 1'b1;
            ma_tag = req_valid ? "R6" : "R5";
        end else if (req_valid) begin
            ma_e0 = 1'b1; ma_i0 = req_dst; ma_w0 = m; ma_d0 = res_lo;
            if (req_wide) begin
                b.idx = req_dst + 1'b1; b.we = m; b.dat = res_hi;
                hq.push_back(b);
                ma_busy = 1'b1;
                ma_tag = "R5";
            end else begin
                ma_done = 1'b1;
                ma_tag = mask_tag();
            end
        end else begin
            ma_tag = "R8";
        end
        // two-port reference
        mb_done = 1'b0; mb_e0 = 1'b0; mb_e1 = 1'b0;
        mb_i0 = '0; mb_w0 = '0; mb_d0 = '0; mb_i1 = '0; mb_w1 = '0; mb_d1 = '0;
        if (rst) begin
            mb_tag = "R1";
        end else if (req_valid) begin
            mb_e0 = 1'b1; mb_i0 = req_dst; mb_w0 = m; mb_d0 = res_lo; mb_done = 1'b1;
            if (req_wide) begin
                mb_e1 = 1'b1; mb_i1 = req_dst + 1'b1; mb_w1 = m; mb_d1 = res_hi;
                mb_tag = "R7";
            end else begin
                mb_tag = mask_tag();
            end
        end else begin
            mb_tag = "R8";
        end
    end

    // ---------------- comparison on every cycle ----------------
    always @(negedge clk) begin
        if (started && !finished) begin
            checks++;
            if (a_busy !== ma_busy || a_done !== ma_done || a_e0 !== ma_e0 ||
                a_i0 !== ma_i0 || a_w0 !== ma_w0 || a_d0 !== ma_d0 ||
                a_e1 !== 1'b0 || a_i1 !== '0 || a_w1 !== '0 || a_d1 !== '0) begin
                bad++;
                $display("FAIL %s u0 t=%0t act busy=%b done=%b en=%b idx=%0d we=%h d0=%h p1en=%b | exp busy=%b done=%b en=%b idx=%0d we=%h d0=%h p1en=0",
                    ma_tag, $time, a_busy, a_done, a_e0, a_i0, a_w0, a_d0[EW-1:0], a_e1,
                    ma_busy, ma_done, ma_e0, ma_i0, ma_w0, ma_d0[EW-1:0]);
            end
            checks++;
            if (b_busy !== 1'b0 || b_done !== mb_done || b_e0 !== mb_e0 ||
                b_i0 !== mb_i0 || b_w0 !== mb_w0 || b_d0 !== mb_d0 ||
                b_e1 !== mb_e1 || b_i1 !== mb_i1 || b_w1 !== mb_w1 || b_d1 !== mb_d1) begin
                bad++;
                $display("FAIL %s u1 t=%0t act busy=%b done=%b en=%b/%b idx=%0d/%0d we=%h/%h | exp busy=0 done=%b en=%b/%b idx=%0d/%0d we=%h/%h",
                    mb_tag, $time, b_busy, b_done, b_e0, b_e1, b_i0, b_i1, b_w0, b_w1,
                    mb_done, mb_e0, mb_e1, mb_i0, mb_i1, mb_w0, mb_w1);
            end
        end
    end

    // ---------------- stimulus ----------------
    function automatic logic [DW-1:0] rnd_data();
        logic [DW-1:0] d;
        for (int k = 0; k < L; k++) d[k*EW +: EW] = $urandom;
        return d;
    endfunction

    function automatic logic [L-1:0] rnd_mask();
        return {$urandom, $urandom};
    endfunction

    // called at a falling edge; holds the request for one cycle
    task automatic issue(input logic [IW-1:0] dst, input logic wide,
                         input logic ld, input logic ign);
        req_valid = 1'b1; req_dst = dst; req_wide = wide;
        req_is_load = ld; req_ignore_mask = ign;
        res_lo = rnd_data(); res_hi = rnd_data();
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    task automatic finish_run();
        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", checks, bad);
        $finish;
    endtask

    initial begin
        repeat (3) @(negedge clk);            // R1: outputs observed under reset
        rst = 1'b0;
        idle(2);                              // R1 / R8: quiet after reset
        // R2: plain 32-bit write under the live mask
        wave_exec = 64'hF0F0_0000_FFFF_0001; load_mask = 64'h0F0F_FFFF_0000_FFFE;
        issue(5'd3, 1'b0, 1'b0, 1'b0);
        idle(1);
        // R3: load uses its own mask
        issue(5'd7, 1'b0, 1'b1, 1'b0);
        idle(1);
        // R4: override with both masks empty
        wave_exec = '0; load_mask = '0;
        issue(5'd9, 1'b0, 1'b1, 1'b1);
        issue(5'd10, 1'b0, 1'b0, 1'b1);
        idle(1);
        // R5 / R6: wide write, masks change and a request arrives in the busy cycle
        wave_exec = 64'h1234_5678_9ABC_DEF0; load_mask = 64'h8000_0000_0000_0001;
        issue(5'd12, 1'b1, 1'b0, 1'b0);
        wave_exec = 64'hFFFF_0000_FFFF_0000; load_mask = 64'h0000_FFFF_0000_FFFF;
        issue(5'd20, 1'b0, 1'b0, 1'b0);
        idle(2);
        // R5: destination wraps from the last register to register 0
        issue(5'd31, 1'b1, 1'b1, 1'b0);
        idle(2);
        // R7: back-to-back wide writes
        issue(5'd1, 1'b1, 1'b0, 1'b0);
        issue(5'd2, 1'b1, 1'b0, 1'b1);
        issue(5'd4, 1'b1, 1'b1, 1'b0);
        idle(2);
        // mixed random traffic
        for (int n = 0; n < 400; n++) begin
            wave_exec = rnd_mask();
            load_mask = rnd_mask();
            if ($urandom_range(0, 9) < 7)
                issue(IW'($urandom), 1'($urandom), 1'($urandom),
                      ($urandom_range(0, 7) == 0));
            else
                idle(1);
        end
        idle(3);
        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        bad++;
        $display("FAIL watchdog: run did not complete, act=hung exp=finished");
        finish_run();
    end

endmodule